// File: doc/BRIEF.md
# Iterative Decoder Early-Stop Checker

This block sits beside an iterative decoder for a serially concatenated code whose outer code is a two-state, rate one-half convolutional code. Both of its generators are 1+D, and it is closed by tail-biting. After each decoding pass, the decoder streams one beat per information position into the checker. Each beat carries the soft value for the information bit and the soft extrinsic values for the two coded bits at that position. The checker slices every soft value to a hard bit. It re-encodes the information decisions through the outer code and compares the result with the coded-bit decisions.

One cycle after the final beat of a pass, the checker reports three things: whether the decoder may stop, whether the pass converged, and how many passes of the current frame have been used. A pass converges only if every coded decision in the frame agrees with the re-encoded value. A stop is also forced when the pass budget is used up. Because the code is tail-biting, the expected pair at the first position depends on the last information bit. The checker therefore keeps the first position's decisions and settles that comparison when the last beat arrives, so no frame buffer is needed.

Top module: `esc_early_stop`

## Requirements
- R1: While reset is asserted and after its release, `res_valid`, `res_stop` and `res_conv` are 0 and `res_iters` is 0.
- R2: A soft value is sliced to hard 1 when it is negative in two's complement and to hard 0 when it is zero or positive.
- R3: At every position k other than the first, both expected coded bits equal u[k] xor u[k-1]. A disagreement in either lane (`code_llr` bits [W-1:0] for lane 0, [2W-1:W] for lane 1) makes the pass unconverged.
- R4: At the first position, the expected coded pair is u[0] xor u[K-1], where K is the number of beats. For a one-beat frame the expected pair is therefore 0.
- R5: `res_valid` is high for exactly the one cycle after the clock edge that accepts a beat with `in_last` high. `res_stop`, `res_conv` and `res_iters` keep their values until the next result.
- R6: `res_conv` is 1 exactly when no position of the pass disagreed, and then `res_stop` is also 1.
- R7: The mismatch record is cleared at the first beat of each pass, so a disagreement in one pass has no effect on the next.
- R8: `frame_start` clears the pass count. Each result reports the count including the pass just finished, which is 1 for the first pass of a frame.
- R9: When the count reaches `MAX_ITER` (default 32), `res_stop` is 1 even for an unconverged pass. Passes after that point report `MAX_ITER` again with `res_stop` at 1.
- R10: Cycles with `in_valid` low between beats have no effect on the outcome.
- R11: A beat presented in the same cycle as `frame_start` is dropped. `frame_start` during a pass abandons that pass, and the next beat is taken as position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse marking a new frame; clears the pass count |
| in_valid | input | 1 | A beat is present this cycle |
| in_last | input | 1 | The beat is the last position of the pass |
| info_llr | input | LLR_W | Soft value of the information bit |
| code_llr | input | 2*LLR_W | Soft extrinsic values of the two coded bits, lane 0 in the low half |
| res_valid | output | 1 | One-cycle pulse: pass result available |
| res_stop | output | 1 | Decoder may stop iterating |
| res_conv | output | 1 | Every coded decision of the pass agreed |
| res_iters | output | $clog2(MAX_ITER+1) | Passes used in this frame, including this one |

## Verification
Every result is registered once. It is therefore due on the clock edge that accepts the last beat of a pass and is sampled at the falling edge that follows that beat. The bench checks `res_valid`, `res_stop`, `res_conv` and `res_iters` together at that single sample point. Before that point it also confirms that nothing was reported on the dropped or idle cycles. Hold behaviour is checked at later falling edges, with no new beat in between.

// File: rtl/esc_pkg.sv
package esc_pkg;
  // Number of coded bits the outer code emits per information bit.
  localparam int unsigned CODE_LANES = 2;

  typedef struct packed {
    logic                  info;
    logic [CODE_LANES-1:0] code;
  } esc_hd_t;
endpackage

// File: rtl/esc_slicer.sv
module esc_slicer #(
  parameter int unsigned W = 6,
  parameter int unsigned N = 3
) (
  input  logic [N*W-1:0] llr,
  output logic [N-1:0]   hd
);
  // One hard decision per lane: negative soft value means bit 1.
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic signed [W-1:0] lane;
    assign lane  = llr[i*W +: W];
    assign hd[i] = (lane < 0);
  end
endmodule

// File: rtl/esc_reencode.sv
module esc_reencode
  import esc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart,
  input  logic    beat,
  input  logic    last,
  input  esc_hd_t hd,
  output logic    first_beat,
  output logic    beat_miss
);
  logic                  at_start_q, at_start_d;
  logic                  prev_q, prev_d;
  logic                  first_u_q, first_u_d;
  logic [CODE_LANES-1:0] first_code_q, first_code_d;

  logic                  exp_mid, mid_miss;
  logic                  wrap_u0, wrap_exp, wrap_miss;
  logic [CODE_LANES-1:0] wrap_code;

  // Ordinary position: state is the previous information bit.
  assign exp_mid  = hd.info ^ prev_q;
  assign mid_miss = !at_start_q && (hd.code != {CODE_LANES{exp_mid}});

  // Tail-biting closure: position 0 is judged once the last bit is known.
  assign wrap_u0   = at_start_q ? hd.info : first_u_q;
  assign wrap_code = at_start_q ? hd.code : first_code_q;
  assign wrap_exp  = wrap_u0 ^ hd.info;
  assign wrap_miss = last && (wrap_code != {CODE_LANES{wrap_exp}});

  assign beat_miss  = beat && (mid_miss || wrap_miss);
  assign first_beat = at_start_q;

  always_comb begin
    at_start_d   = at_start_q;
    prev_d       = prev_q;
    first_u_d    = first_u_q;
    first_code_d = first_code_q;
    if (restart) begin
      at_start_d = 1'b1;
    end else if (beat) begin
      at_start_d = last;
      prev_d     = hd.info;
      if (at_start_q) begin
        first_u_d    = hd.info;
        first_code_d = hd.code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_start_q   <= 1'b1;
      prev_q       <= 1'b0;
      first_u_q    <= 1'b0;
      first_code_q <= '0;
    end else begin
      at_start_q   <= at_start_d;
      prev_q       <= prev_d;
      first_u_q    <= first_u_d;
      first_code_q <= first_code_d;
    end
  end

  // R4: the first beat of a longer pass is never judged on arrival.
  a_r4_first_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && at_start_q && !last) |-> !beat_miss);
  // R11: a restart makes the next accepted beat position 0.
  a_r11_restart_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> at_start_q);
endmodule

// File: rtl/esc_iter_ctrl.sv
module esc_iter_ctrl #(
  parameter int unsigned MAX_ITER = 32,
  parameter int unsigned CNT_W    = $clog2(MAX_ITER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             beat,
  input  logic             last,
  input  logic             first_beat,
  input  logic             beat_miss,
  output logic             res_valid,
  output logic             res_stop,
  output logic             res_conv,
  output logic [CNT_W-1:0] res_iters
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ITER);

  logic             fail_q, fail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_next;
  logic             vld_q, vld_d;
  logic             stop_q, stop_d;
  logic             conv_q, conv_d;
  logic [CNT_W-1:0] iters_q, iters_d;
  logic             fail_all, done;

  assign done     = beat && last;
  assign fail_all = (first_beat ? 1'b0 : fail_q) | beat_miss;
  assign cnt_next = (cnt_q == CAP) ? CAP : cnt_q + 1'b1;

  always_comb begin
    fail_d  = fail_q;
    cnt_d   = cnt_q;
    vld_d   = done;
    stop_d  = stop_q;
    conv_d  = conv_q;
    iters_d = iters_q;
    if (beat) fail_d = fail_all;
    if (restart) begin
      cnt_d = '0;
    end else if (done) begin
      cnt_d   = cnt_next;
      conv_d  = !fail_all;
      stop_d  = !fail_all || (cnt_next == CAP);
      iters_d = cnt_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      stop_q  <= 1'b0;
      conv_q  <= 1'b0;
      iters_q <= '0;
    end else begin
      fail_q  <= fail_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      stop_q  <= stop_d;
      conv_q  <= conv_d;
      iters_q <= iters_d;
    end
  end

  assign res_valid = vld_q;
  assign res_stop  = stop_q;
  assign res_conv  = conv_q;
  assign res_iters = iters_q;

  // R5: a result appears only after an accepted last beat.
  a_r5_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(done));
  // R5: outputs hold between results.
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> ($stable(stop_q) && $stable(conv_q) && $stable(iters_q)));
  // R8: frame_start clears the pass count.
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R8: an unsaturated pass advances the reported count by one.
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart && cnt_q != CAP) |=> (iters_q == $past(cnt_q) + 1'b1));
  // R9: the count never exceeds the budget, and reaching it forces stop.
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    iters_q <= CAP);
  a_r9_cap_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && iters_q == CAP) |-> stop_q);
  // R6: a converged pass always stops.
  a_r6_conv_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && conv_q) |-> stop_q);
endmodule

// File: rtl/esc_early_stop.sv
module esc_early_stop
  import esc_pkg::*;
#(
  parameter int unsigned LLR_W    = 6,
  parameter int unsigned MAX_ITER = 32,
  localparam int unsigned CNT_W   = $clog2(MAX_ITER + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_start,
  input  logic                       in_valid,
  input  logic                       in_last,
  input  logic [LLR_W-1:0]           info_llr,
  input  logic [CODE_LANES*LLR_W-1:0] code_llr,
  output logic                       res_valid,
  output logic                       res_stop,
  output logic                       res_conv,
  output logic [CNT_W-1:0]           res_iters
);
  localparam int unsigned N_SLICE = CODE_LANES + 1;

  logic [N_SLICE-1:0] hd_bits;
  esc_hd_t            hd;
  logic               beat, first_beat, beat_miss;

  // Beats coinciding with frame_start are dropped.
  assign beat = in_valid && !frame_start;

  esc_slicer #(.W(LLR_W), .N(N_SLICE)) u_slice (
    .llr ({info_llr, code_llr}),
    .hd  (hd_bits)
  );

  assign hd.info = hd_bits[N_SLICE-1];
  assign hd.code = hd_bits[CODE_LANES-1:0];

  esc_reencode u_reenc (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (frame_start),
    .beat       (beat),
    .last       (in_last),
    .hd         (hd),
    .first_beat (first_beat),
    .beat_miss  (beat_miss)
  );

  esc_iter_ctrl #(.MAX_ITER(MAX_ITER), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (frame_start),
    .beat       (beat),
    .last       (in_last),
    .first_beat (first_beat),
    .beat_miss  (beat_miss),
    .res_valid  (res_valid),
    .res_stop   (res_stop),
    .res_conv   (res_conv),
    .res_iters  (res_iters)
  );
endmodule

// File: tb/esc_early_stop_tb.sv
module esc_early_stop_tb;
  localparam int W    = 6;
  localparam int MAXI = 32;
  localparam int CW   = $clog2(MAXI + 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            frame_start, in_valid, in_last;
  logic [W-1:0]    info_llr;
  logic [2*W-1:0]  code_llr;
  logic            res_valid, res_stop, res_conv;
  logic [CW-1:0]   res_iters;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  esc_early_stop #(.LLR_W(W), .MAX_ITER(MAXI)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_last(in_last), .info_llr(info_llr),
    .code_llr(code_llr), .res_valid(res_valid), .res_stop(res_stop),
    .res_conv(res_conv), .res_iters(res_iters)
  );

  typedef struct packed {
    logic [3:0] len;
    logic [7:0] info;
    logic [7:0] m0;
    logic [7:0] m1;
    logic       conv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{4'd8, 8'hA5, 8'h00, 8'h00, 1'b1},
    '{4'd8, 8'h3C, 8'h10, 8'h00, 1'b0},
    '{4'd8, 8'hFF, 8'h00, 8'h01, 1'b0},
    '{4'd8, 8'h81, 8'h80, 8'h00, 1'b0},
    '{4'd1, 8'h01, 8'h00, 8'h00, 1'b1},
    '{4'd1, 8'h01, 8'h01, 8'h00, 1'b0},
    '{4'd5, 8'h13, 8'h00, 8'h00, 1'b1},
    '{4'd3, 8'h06, 8'h00, 8'h04, 1'b0},
    '{4'd2, 8'h02, 8'h00, 8'h00, 1'b1}
  };

  // Bit 1 -> negative value, bit 0 -> zero or positive (R2).
  function automatic logic [W-1:0] mk_llr(input logic b, input int mag);
    if (b) return W'(-(mag + 1));
    else   return W'(mag);
  endfunction

  task automatic check(input logic ok, input string tag,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_res(input string tag, input logic e_stop,
                           input logic e_conv, input int e_iters);
    check(res_valid == 1'b1, {tag, " valid"}, int'(res_valid), 1);
    check(res_stop == e_stop, {tag, " stop"}, int'(res_stop), int'(e_stop));
    check(res_conv == e_conv, {tag, " conv"}, int'(res_conv), int'(e_conv));
    check(int'(res_iters) == e_iters, {tag, " iters"}, int'(res_iters), e_iters);
  endtask

  task automatic pulse_frame_start();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // Streams one pass; returns at the falling edge where the result is due.
  task automatic run_pass(input int len, input logic [7:0] info,
                          input logic [7:0] m0, input logic [7:0] m1,
                          input int gap);
    for (int k = 0; k < len; k++) begin
      logic u, p, c;
      u = info[k];
      p = info[(k + len - 1) % len];
      c = u ^ p;
      in_valid = 1'b1;
      in_last  = (k == len - 1);
      info_llr = mk_llr(u, k % 4);
      code_llr = {mk_llr(c ^ m1[k], (k + 1) % 4), mk_llr(c ^ m0[k], (k + 2) % 4)};
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (k != len - 1) begin
        for (int g = 0; g < gap; g++) begin
          check(res_valid == 1'b0, "R10 no result during gap", int'(res_valid), 0);
          @(negedge clk);
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    info_llr = '0; code_llr = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 0 && res_stop == 0 && res_conv == 0, "R1 reset flags",
          int'({res_valid, res_stop, res_conv}), 0);
    check(res_iters == 0, "R1 reset count", int'(res_iters), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 0 && res_iters == 0, "R1 after release",
          int'(res_iters), 0);

    // Table: one fresh frame per entry (R2 R3 R4 R6).
    for (int i = 0; i < NV; i++) begin
      pulse_frame_start();
      run_pass(int'(VEC[i].len), VEC[i].info, VEC[i].m0, VEC[i].m1, 0);
      check_res($sformatf("R3/R4/R6 vector %0d", i), VEC[i].conv, VEC[i].conv, 1);
    end

    // R5: result is a one-cycle pulse and outputs hold.
    @(negedge clk);
    check(res_valid == 0, "R5 pulse width", int'(res_valid), 0);
    repeat (3) @(negedge clk);
    check(res_stop == 1 && res_conv == 1 && res_iters == 1, "R5 hold",
          int'({res_stop, res_conv}), 3);

    // R7 R8: failed pass then clean pass in one frame.
    pulse_frame_start();
    run_pass(6, 8'h2D, 8'h08, 8'h00, 0);
    check_res("R8 first pass", 1'b0, 1'b0, 1);
    run_pass(6, 8'h2D, 8'h00, 8'h00, 0);
    check_res("R7 fail cleared", 1'b1, 1'b1, 2);

    // R10: idle cycles between beats.
    pulse_frame_start();
    run_pass(7, 8'h5B, 8'h00, 8'h00, 2);
    check_res("R10 gaps converge", 1'b1, 1'b1, 1);
    pulse_frame_start();
    run_pass(7, 8'h5B, 8'h00, 8'h20, 3);
    check_res("R10 gaps mismatch", 1'b0, 1'b0, 1);

    // R11: beat during frame_start is dropped; mid-pass restart.
    @(negedge clk);
    frame_start = 1'b1; in_valid = 1'b1; in_last = 1'b1;
    info_llr = mk_llr(1'b1, 0); code_llr = {mk_llr(1'b1, 0), mk_llr(1'b1, 0)};
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    check(res_valid == 0, "R11 dropped beat", int'(res_valid), 0);
    run_pass(3, 8'h05, 8'h02, 8'h00, 0);
    check_res("R11 partial pass", 1'b0, 1'b0, 1);
    // Abandon an 8-beat pass after three beats, then restart cleanly.
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_last = 1'b0;
      info_llr = mk_llr(1'b1, 1); code_llr = {mk_llr(1'b1, 1), mk_llr(1'b1, 1)};
      @(negedge clk);
    end
    in_valid = 1'b0;
    pulse_frame_start();
    run_pass(4, 8'h09, 8'h00, 8'h00, 0);
    check_res("R11 restart mid-pass", 1'b1, 1'b1, 1);

    // R9: cap at MAX_ITER with a persistent mismatch, then saturation.
    pulse_frame_start();
    for (int it = 1; it <= MAXI + 1; it++) begin
      run_pass(2, 8'h01, 8'h02, 8'h00, 0);
      if (it < MAXI)
        check_res($sformatf("R9 pass %0d", it), 1'b0, 1'b0, it);
      else
        check_res($sformatf("R9 capped pass %0d", it), 1'b1, 1'b0, MAXI);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule